// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

The block keeps wall-clock time and a calendar. A one-cycle pulse on `tick` means that one second has passed. Each pulse advances the seconds. A carry then ripples through minutes, hours, day of month, month and year. Every time and date field is held as two-digit BCD. A 3-bit weekday counter steps on each day change.

The `mode24` input chooses how hours are counted. With `mode24` high, hours run 00 to 23. With `mode24` low, hours run 1 to 12, and a separate `pm` flag tells morning from afternoon.

Software or a bus bridge sets the time by driving all fields on the load bus and pulsing `load`. A load in the same cycle as a tick takes priority, and that tick is dropped. The clock keeps counting for as long as the load is not strobed, so a new time can be assembled outside the block without stopping it.

Top module: `bcd_calendar`

## Requirements
- R1: Seconds and minutes count in BCD from 00 to 59. When seconds pass 59 they return to 00, and minutes advance by one on that same tick; minutes change on no other tick.
- R2: With `mode24`=1, hours count 00 to 23 in BCD. The step from 23 back to 00 advances the date.
- R3: With `mode24`=0, hours count 01 to 12 in BCD.
  - On the step from 11 to 12, `pm` toggles.
  - On the step from 12 to 01, `pm` stays the same.
  - The date advances when the hour moves from 11 with `pm`=1 to 12 with `pm`=0.
  - With `mode24`=1, ticks never change `pm`.
- R4: After the last day of a month, the date returns to 01 and the month advances.
  - Months 04, 06, 09 and 11 end on day 30.
  - Months 01, 03, 05, 07, 08, 10 and 12 end on day 31.
- R5: Month 02 ends on day 29 when the year's value is divisible by 4 (00 counts as divisible), and on day 28 otherwise.
- R6: Month 12 rolls over to 01 and advances the year. Year 99 rolls over to 00.
- R7: `dow` cycles 0,1,2,3,4,5,6,0. It advances exactly on the ticks that change the date, and at no other time.
- R8: While `rst_n` is low, and until the first tick or load after it rises, the outputs hold their reset values:
  - sec 00, min 00, pm 0;
  - hour 00 when `mode24`=1, or 12 when `mode24`=0;
  - date 01, month 01, year 00;
  - dow 0.
- R9: When `load` is high at a clock edge, every field takes its load-bus value at that edge. A `tick` in the same cycle is ignored.
- R10: In a cycle with neither `tick` nor `load`, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-second advance pulse |
| mode24 | input | 1 | 1 selects 24-hour counting, 0 selects 12-hour counting |
| load | input | 1 | Load strobe for all fields |
| ld_sec | input | 8 | BCD seconds to load |
| ld_min | input | 8 | BCD minutes to load |
| ld_hour | input | 8 | BCD hour to load |
| ld_pm | input | 1 | AM/PM flag to load |
| ld_date | input | 8 | BCD day of month to load |
| ld_month | input | 8 | BCD month to load |
| ld_year | input | 8 | BCD year to load |
| ld_dow | input | 3 | Weekday to load |
| sec | output | 8 | BCD seconds |
| min | output | 8 | BCD minutes |
| hour | output | 8 | BCD hour |
| pm | output | 1 | Afternoon flag, used in 12-hour mode |
| date | output | 8 | BCD day of month |
| month | output | 8 | BCD month |
| year | output | 8 | BCD year |
| dow | output | 3 | Weekday, 0 to 6 |

## Verification
Every field is a single register. A tick or a load sampled at one rising edge is visible on all outputs directly after that edge, even when the carry ripples through every field at once. The bench drives its stimulus on the falling edge. It then waits for the next falling edge and compares all fields against a binary model of the time, converted to BCD. Reset values are checked both while reset is held and after it is released. Hold behaviour is checked one full cycle after an idle cycle.

// File: rtl/bcd_calendar.sv
module bcd_calendar (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       mode24,
  input  logic       load,
  input  logic [7:0] ld_sec,
  input  logic [7:0] ld_min,
  input  logic [7:0] ld_hour,
  input  logic       ld_pm,
  input  logic [7:0] ld_date,
  input  logic [7:0] ld_month,
  input  logic [7:0] ld_year,
  input  logic [2:0] ld_dow,
  output logic [7:0] sec,
  output logic [7:0] min,
  output logic [7:0] hour,
  output logic       pm,
  output logic [7:0] date,
  output logic [7:0] month,
  output logic [7:0] year,
  output logic [2:0] dow
);

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  logic [7:0] yr_bin, last_day, hour_nx;
  logic       leap, sec_end, min_end, hour_end, day_end, mon_end;
  logic       c_min, c_hour, c_day, c_mon, c_yr;

  assign yr_bin   = {4'd0, year[7:4]} * 8'd10 + {4'd0, year[3:0]};
  assign leap     = (yr_bin[1:0] == 2'b00);
  assign last_day = (month == 8'h02) ? (leap ? 8'h29 : 8'h28) :
                    (month == 8'h04 || month == 8'h06 || month == 8'h09 || month == 8'h11) ? 8'h30 : 8'h31;

  assign sec_end  = (sec == 8'h59);
  assign min_end  = (min == 8'h59);
  assign hour_end = mode24 ? (hour == 8'h23) : (hour == 8'h11 && pm);
  assign day_end  = (date == last_day);
  assign mon_end  = (month == 8'h12);

  assign c_min  = tick & sec_end;
  assign c_hour = c_min & min_end;
  assign c_day  = c_hour & hour_end;
  assign c_mon  = c_day & day_end;
  assign c_yr   = c_mon & mon_end;

  assign hour_nx = mode24 ? (hour_end ? 8'h00 : bcd_inc(hour))
                          : ((hour == 8'h12) ? 8'h01 : bcd_inc(hour));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec   <= 8'h00;
      min   <= 8'h00;
      hour  <= mode24 ? 8'h00 : 8'h12;
      pm    <= 1'b0;
      date  <= 8'h01;
      month <= 8'h01;
      year  <= 8'h00;
      dow   <= 3'd0;
    end else if (load) begin
      sec   <= ld_sec;
      min   <= ld_min;
      hour  <= ld_hour;
      pm    <= ld_pm;
      date  <= ld_date;
      month <= ld_month;
      year  <= ld_year;
      dow   <= ld_dow;
    end else if (tick) begin
      sec <= sec_end ? 8'h00 : bcd_inc(sec);
      if (c_min) min <= min_end ? 8'h00 : bcd_inc(min);
      if (c_hour) begin
        hour <= hour_nx;
        if (!mode24 && hour == 8'h11) pm <= ~pm;
      end
      if (c_day) begin
        date <= day_end ? 8'h01 : bcd_inc(date);
        dow  <= (dow == 3'd6) ? 3'd0 : dow + 3'd1;
      end
      if (c_mon) month <= mon_end ? 8'h01 : bcd_inc(month);
      if (c_yr)  year  <= (year == 8'h99) ? 8'h00 : bcd_inc(year);
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable({sec, min, hour, pm, date, month, year, dow})); // R10

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sec == $past(ld_sec) && min == $past(ld_min) && hour == $past(ld_hour) &&
              pm == $past(ld_pm) && date == $past(ld_date) && month == $past(ld_month) &&
              year == $past(ld_year) && dow == $past(ld_dow))); // R9

  AST_DOW_WITH_DATE: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ((dow != $past(dow)) == (date != $past(date)))); // R7

  AST_PM_24H_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && mode24) |=> $stable(pm)); // R3

  AST_MIN_ONLY_AT_59: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && sec != 8'h59) |=> $stable(min)); // R1

  AST_YEAR_ONLY_WITH_MONTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && month != 8'h12) |=> $stable(year)); // R6

endmodule

// File: tb/bcd_calendar_tb.sv
module bcd_calendar_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0, tick = 1'b0, mode24 = 1'b1, load = 1'b0;
  logic [7:0] ld_sec = '0, ld_min = '0, ld_hour = '0, ld_date = '0, ld_month = '0, ld_year = '0;
  logic ld_pm = 1'b0;
  logic [2:0] ld_dow = '0;
  logic [7:0] sec, min, hour, date, month, year;
  logic pm;
  logic [2:0] dow;

  int checks = 0, errors = 0;
  int s, m, h, d, mo, y, w;
  bit md, pmh;

  always #4 clk = ~clk;

  bcd_calendar u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode24(mode24), .load(load),
    .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour), .ld_pm(ld_pm),
    .ld_date(ld_date), .ld_month(ld_month), .ld_year(ld_year), .ld_dow(ld_dow),
    .sec(sec), .min(min), .hour(hour), .pm(pm), .date(date), .month(month),
    .year(year), .dow(dow));

  function automatic logic [7:0] bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int mdays(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] hour_bcd();
    if (md) return bcd(h);
    return bcd((h % 12 == 0) ? 12 : h % 12);
  endfunction

  function automatic logic pm_exp();
    return md ? pmh : (h >= 12);
  endfunction

  task automatic chk(input string tag);
    logic [51:0] act, exp;
    act = {sec, min, hour, pm, date, month, year, dow};
    exp = {bcd(s), bcd(m), hour_bcd(), pm_exp(), bcd(d), bcd(mo), bcd(y), 3'(w)};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_tick();
    s++;
    if (s == 60) begin
      s = 0; m++;
      if (m == 60) begin
        m = 0; h++;
        if (h == 24) begin
          h = 0; d++; w = (w + 1) % 7;
          if (d > mdays(mo, y)) begin
            d = 1; mo++;
            if (mo == 13) begin mo = 1; y = (y + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic do_reset(input bit mode);
    md = mode; mode24 = mode; rst_n = 1'b0;
    s = 0; m = 0; h = 0; d = 1; mo = 1; y = 0; w = 0; pmh = 1'b0;
    @(negedge clk);
    chk("R8");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8");
  endtask

  task automatic do_load(input int ns, input int nm, input int nh, input int nd,
                         input int nmo, input int ny, input int nw, input bit np,
                         input bit with_tick, input string tag);
    s = ns; m = nm; h = nh; d = nd; mo = nmo; y = ny; w = nw; pmh = np;
    ld_sec = bcd(s); ld_min = bcd(m); ld_hour = hour_bcd(); ld_pm = pm_exp();
    ld_date = bcd(d); ld_month = bcd(mo); ld_year = bcd(y); ld_dow = 3'(w);
    load = 1'b1; tick = with_tick;
    @(negedge clk);
    load = 1'b0; tick = 1'b0;
    chk(tag);
  endtask

  task automatic do_tick(input string tag);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    model_tick();
    chk(tag);
  endtask

  task automatic do_idle(input string tag);
    @(negedge clk);
    chk(tag);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R8 in 12-hour mode, then a full day of ticks: R1, R3
    do_reset(1'b0);
    for (int i = 0; i < 86400; i++) do_tick("R3");
    do_idle("R10");
    do_idle("R10");

    // R8 in 24-hour mode and every hour boundary: R2, R1
    do_reset(1'b1);
    for (int hh = 0; hh < 24; hh++) begin
      do_load(58, 59, hh, 15, 6, 21, 3, 1'b1, 1'b0, "R9");
      for (int k = 0; k < 3; k++) do_tick("R2");
      do_idle("R10");
    end

    // 12-hour boundaries loaded directly: R3
    do_reset(1'b0);
    for (int hh = 0; hh < 24; hh++) begin
      do_load(59, 59, hh, 10, 3, 5, 1, 1'b0, 1'b0, "R9");
      do_tick("R3");
    end

    // Month ends for several years, including the century wrap: R4, R5, R6
    do_reset(1'b1);
    for (int yi = 0; yi < 12; yi++) begin
      int yy;
      yy = (yi < 8) ? yi : 88 + yi;
      for (int mm = 1; mm <= 12; mm++) begin
        for (int dd = 27; dd <= mdays(mm, yy); dd++) begin
          string tg;
          do_load(59, 59, 23, dd, mm, yy, (dd + mm + yy) % 7, 1'b0, 1'b0, "R9");
          tg = (mm == 2) ? "R5" : (mm == 12 && dd == 31) ? "R6" : "R4";
          do_tick(tg);
        end
      end
    end

    // February over a whole century: R5
    for (int yy = 0; yy < 100; yy++) begin
      do_load(59, 59, 23, 28, 2, yy, 2, 1'b0, 1'b0, "R9");
      do_tick("R5");
      do_tick("R5");
    end

    // Weekday steps only on a date change: R7
    for (int ww = 0; ww < 7; ww++) begin
      do_load(58, 59, 23, 5, 7, 9, ww, 1'b0, 1'b0, "R9");
      do_tick("R7");
      do_tick("R7");
      do_idle("R7");
    end

    // Load with a concurrent tick drops the tick: R9
    do_load(30, 59, 23, 31, 12, 99, 6, 1'b1, 1'b1, "R9");
    do_idle("R10");
    do_load(59, 59, 23, 31, 12, 99, 6, 1'b0, 1'b1, "R9");
    do_tick("R6");

    // pm untouched by ticks in 24-hour mode: R3
    do_load(59, 59, 11, 1, 1, 1, 0, 1'b1, 1'b0, "R9");
    do_tick("R3");
    do_load(59, 59, 23, 1, 1, 1, 0, 1'b1, 1'b0, "R9");
    do_tick("R3");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule